// File: doc/BRIEF.md
# DDS Control Word Loader

This block collects a 40-bit tuning word from an external controller and hands it to a direct digital synthesis core. The controller chooses one of two loading styles with a select input: five byte-wide writes, each marked by a rising edge of a word strobe, or forty single-bit writes, each marked by the same strobe. The assembled word sits in an input register and does nothing until a separate commit strobe rises. On that edge it moves into the active register, which drives the frequency, phase, power-down and mode outputs.

Both strobes come from a slower, unrelated controller. They pass through a two-flop synchronizer into the reference clock domain and are edge-detected there. Each strobe level must therefore last at least three reference cycles. At commit time, a word that carries a mode code reserved for the current loading style is discarded, and an error flag rises for one cycle.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst` is high, all outputs go to zero and the byte pointer goes to byte 0. All outputs read zero until the first accepted commit.
- R2: The 40-bit word places the frequency at bits [31:0], the mode code at [33:32], power-down at bit 34 and the phase at [39:35].
- R3: When `serial_sel` is 0, each word-strobe rising edge stores `bus_in` into the byte that the pointer selects. Byte 0 is word bits [39:32], so it carries phase bits [7:3], power-down bit 2 and mode bits [1:0]. Bytes 1 to 4 carry the frequency, most significant byte first.
- R4: When `serial_sel` is 1, each word-strobe rising edge shifts `ser_in` in. After 40 shifts, the first bit sent is word bit 0 and the last is word bit 39.
- R5: The outputs change only on a commit. Loading bytes or bits leaves them unchanged.
- R6: A commit edge returns the byte pointer to byte 0, so the next parallel write goes to byte 0 even after a partial load.
- R7: At commit time, a mode code of 01 or 10 in parallel mode, or 01, 10 or 11 in serial mode, is reserved. A reserved word leaves the outputs unchanged and raises `err_pulse` for exactly one cycle. Code 00 is accepted in both modes, and code 11 is accepted in parallel mode.
- R8: After a write to byte 4, the byte pointer wraps to byte 0, so a sixth parallel write overwrites byte 0.
- R9: A commit-strobe rise that is stable before reference edge 1 shows on the outputs after edge 3 and not after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Active-high reset, held for at least 5 cycles |
| serial_sel | input | 1 | 1 selects bit-serial loading, 0 selects byte loading |
| wr_strobe | input | 1 | Asynchronous word strobe; a rising edge loads one byte or bit |
| upd_strobe | input | 1 | Asynchronous commit strobe; a rising edge commits the word |
| bus_in | input | 8 | Byte data for parallel loading |
| ser_in | input | 1 | Bit data for serial loading |
| freq_word | output | 32 | Active frequency word |
| phase_word | output | 5 | Active phase word |
| pwr_down | output | 1 | Active power-down flag |
| mode_code | output | 2 | Active mode code |
| err_pulse | output | 1 | One-cycle flag for a rejected reserved-mode commit |

## Verification
Both strobes pass through two synchronizer flops and one edge-detect flop. A strobe rise therefore acts on the third reference edge. Loaded data lands in the input register on that edge, and a committed word reaches the outputs and `err_pulse` on that same edge. The bench drives every input on falling edges and keeps each strobe level for four cycles, so every effect has settled before the next falling-edge sample. A directed check samples the outputs after edges 2 and 3 to fix the commit latency exactly. The one-cycle error flag is counted on every falling edge and compared after each commit.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
   localparam int MODE_W = 2;

   // Mode code acceptance: serial loads allow only 00, parallel loads reject 01 and 10.
   function automatic logic mode_reserved(input logic serial, input logic [MODE_W-1:0] code);
      if (serial) return (code != 2'b00);
      return (code == 2'b01) || (code == 2'b10);
   endfunction
endpackage

// File: rtl/dds_ldr_edge.sv
module dds_ldr_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dds_ldr_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], async_in};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dds_ldr_input.sv
module dds_ldr_input #(
   parameter int WORD_W = 40,
   parameter int BUS_W  = 8,
   localparam int NBYTES = WORD_W / BUS_W,
   localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_rise,
   input  logic              upd_rise,
   input  logic              serial_sel,
   input  logic [BUS_W-1:0]  bus_in,
   input  logic              ser_in,
   output logic [WORD_W-1:0] in_word,
   output logic [PTR_W-1:0]  byte_ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

   logic [NBYTES-1:0] lane_hit;
   logic [WORD_W-1:0] par_next;
   logic [WORD_W-1:0] nxt;

   // One lane per byte slot; byte 0 sits at the top of the word.
   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign lane_hit[k] = (byte_ptr == PTR_W'(k));
      assign par_next[WORD_W-1-k*BUS_W -: BUS_W] =
         lane_hit[k] ? bus_in : in_word[WORD_W-1-k*BUS_W -: BUS_W];
   end

   always_comb begin
      nxt = in_word;
      if (wr_rise) begin
         if (serial_sel) nxt = {ser_in, in_word[WORD_W-1:1]};
         else            nxt = par_next;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         in_word  <= '0;
         byte_ptr <= '0;
      end else begin
         in_word <= nxt;
         if (upd_rise)
            byte_ptr <= '0;
         else if (wr_rise && !serial_sel)
            byte_ptr <= (byte_ptr == LAST) ? '0 : byte_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/dds_ldr_commit.sv
module dds_ldr_commit
   import dds_ldr_pkg::*;
#(
   parameter int WORD_W   = 40,
   parameter int MODE_LSB = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_rise,
   input  logic              serial_sel,
   input  logic [WORD_W-1:0] in_word,
   output logic [WORD_W-1:0] active,
   output logic              err_pulse
);
   logic bad_code;
   assign bad_code = mode_reserved(serial_sel, in_word[MODE_LSB +: MODE_W]);

   always_ff @(posedge clk) begin
      if (rst) begin
         active    <= '0;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= upd_rise & bad_code;
         if (upd_rise && !bad_code) active <= in_word;
      end
   end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
   import dds_ldr_pkg::*;
#(
   parameter int FREQ_W      = 32,
   parameter int PHASE_W     = 5,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W   = FREQ_W + MODE_W + 1 + PHASE_W,
   localparam int NBYTES   = WORD_W / BUS_W,
   localparam int PTR_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int MODE_LSB = FREQ_W,
   localparam int PD_BIT   = FREQ_W + MODE_W,
   localparam int PH_LSB   = PD_BIT + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               serial_sel,
   input  logic               wr_strobe,
   input  logic               upd_strobe,
   input  logic [BUS_W-1:0]   bus_in,
   input  logic               ser_in,
   output logic [FREQ_W-1:0]  freq_word,
   output logic [PHASE_W-1:0] phase_word,
   output logic               pwr_down,
   output logic [MODE_W-1:0]  mode_code,
   output logic               err_pulse
);
   if (WORD_W % BUS_W != 0) begin : g_bad_split
      $error("dds_word_loader: word width must be a whole number of bus bytes");
   end

   logic              wr_rise;
   logic              upd_rise;
   logic [WORD_W-1:0] in_word;
   logic [WORD_W-1:0] active;
   logic [PTR_W-1:0]  byte_ptr;

   dds_ldr_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst(rst), .async_in(wr_strobe), .rise(wr_rise));

   dds_ldr_edge #(.STAGES(SYNC_STAGES)) u_upd_sync (
      .clk(clk), .rst(rst), .async_in(upd_strobe), .rise(upd_rise));

   dds_ldr_input #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_input (
      .clk(clk), .rst(rst), .wr_rise(wr_rise), .upd_rise(upd_rise),
      .serial_sel(serial_sel), .bus_in(bus_in), .ser_in(ser_in),
      .in_word(in_word), .byte_ptr(byte_ptr));

   dds_ldr_commit #(.WORD_W(WORD_W), .MODE_LSB(MODE_LSB)) u_commit (
      .clk(clk), .rst(rst), .upd_rise(upd_rise), .serial_sel(serial_sel),
      .in_word(in_word), .active(active), .err_pulse(err_pulse));

   assign freq_word  = active[FREQ_W-1:0];
   assign mode_code  = active[MODE_LSB +: MODE_W];
   assign pwr_down   = active[PD_BIT];
   assign phase_word = active[PH_LSB +: PHASE_W];
endmodule

// File: rtl/dds_ldr_checker.sv
module dds_ldr_checker #(
   parameter int FREQ_W  = 32,
   parameter int PHASE_W = 5,
   parameter int NBYTES  = 5,
   parameter int PTR_W   = 3
) (
   input logic               clk,
   input logic               rst,
   input logic               serial_sel,
   input logic               upd_rise,
   input logic [PTR_W-1:0]   byte_ptr,
   input logic [FREQ_W-1:0]  freq_word,
   input logic [PHASE_W-1:0] phase_word,
   input logic               pwr_down,
   input logic [1:0]         mode_code,
   input logic               err_pulse
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (freq_word == '0 && phase_word == '0 && !pwr_down &&
               mode_code == '0 && !err_pulse && byte_ptr == '0));

   assert_hold_between_commits_R5: assert property (@(posedge clk) disable iff (rst)
      !upd_rise |=> ($stable(freq_word) && $stable(phase_word) &&
                     $stable(pwr_down) && $stable(mode_code)));

   assert_ptr_restart_R6: assert property (@(posedge clk) disable iff (rst)
      upd_rise |=> (byte_ptr == '0));

   assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
      byte_ptr < PTR_W'(NBYTES));

   assert_serial_ptr_idle_R4: assert property (@(posedge clk) disable iff (rst)
      (serial_sel && !upd_rise) |=> $stable(byte_ptr));

   assert_err_follows_commit_R7: assert property (@(posedge clk) disable iff (rst)
      err_pulse |-> $past(upd_rise));

   assert_err_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      err_pulse |=> !err_pulse);
endmodule

bind dds_word_loader dds_ldr_checker #(
   .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .NBYTES(NBYTES), .PTR_W(PTR_W)
) u_chk (
   .clk(clk), .rst(rst), .serial_sel(serial_sel), .upd_rise(upd_rise),
   .byte_ptr(byte_ptr), .freq_word(freq_word), .phase_word(phase_word),
   .pwr_down(pwr_down), .mode_code(mode_code), .err_pulse(err_pulse));

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        serial_sel = 1'b0;
   logic        wr_strobe = 1'b0;
   logic        upd_strobe = 1'b0;
   logic [7:0]  bus_in = '0;
   logic        ser_in = 1'b0;
   logic [31:0] freq_word;
   logic [4:0]  phase_word;
   logic        pwr_down;
   logic [1:0]  mode_code;
   logic        err_pulse;

   int vectors = 0;
   int fails = 0;
   int err_seen = 0;
   int err_exp = 0;
   int m_ptr = 0;
   logic [39:0] m_in = '0;
   logic [39:0] m_act = '0;

   always #2 clk = ~clk;

   dds_word_loader uut (
      .clk(clk), .rst(rst), .serial_sel(serial_sel), .wr_strobe(wr_strobe),
      .upd_strobe(upd_strobe), .bus_in(bus_in), .ser_in(ser_in),
      .freq_word(freq_word), .phase_word(phase_word), .pwr_down(pwr_down),
      .mode_code(mode_code), .err_pulse(err_pulse));

   always @(negedge clk) if (!rst && err_pulse === 1'b1) err_seen++;

   function automatic logic exp_reserved(input logic ser, input logic [1:0] c);
      if (ser) return c != 2'b00;
      return c == 2'b01 || c == 2'b10;
   endfunction

   function automatic logic [39:0] out_word();
      return {phase_word, pwr_down, mode_code, freq_word};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic strobe_wr();
      wr_strobe = 1'b1; repeat (4) @(negedge clk);
      wr_strobe = 1'b0; repeat (4) @(negedge clk);
   endtask

   task automatic par_byte(input logic [7:0] b);
      serial_sel = 1'b0; bus_in = b;
      strobe_wr();
      m_in[39-8*m_ptr -: 8] = b;
      m_ptr = (m_ptr == 4) ? 0 : m_ptr + 1;
   endtask

   task automatic ser_bit(input logic b);
      serial_sel = 1'b1; ser_in = b;
      strobe_wr();
      m_in = {b, m_in[39:1]};
   endtask

   task automatic load_par(input logic [39:0] w);
      for (int k = 0; k < 5; k++) par_byte(w[39-8*k -: 8]);
   endtask

   task automatic load_ser(input logic [39:0] w);
      for (int i = 0; i < 40; i++) ser_bit(w[i]);
   endtask

   task automatic commit(input string req);
      upd_strobe = 1'b1; repeat (4) @(negedge clk);
      upd_strobe = 1'b0; repeat (4) @(negedge clk);
      if (exp_reserved(serial_sel, m_in[33:32])) err_exp++;
      else m_act = m_in;
      m_ptr = 0;
      check({req, " outputs after commit"}, 64'(out_word()), 64'(m_act));
      check({req, " error pulse count"}, 64'(err_seen), 64'(err_exp));
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      repeat (6) @(negedge clk);
      check("R1 reset outputs", 64'(out_word()), 64'd0);
      check("R1 reset error flag", 64'(err_pulse), 64'd0);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R3 / R2: parallel load, byte 0 = {phase, pd, mode}
      load_par({5'h15, 1'b1, 2'b00, 32'h1234_5678});
      check("R5 no change while loading", 64'(out_word()), 64'd0);
      commit("R3");
      check("R2 frequency field", 64'(freq_word), 64'h1234_5678);
      check("R2 phase field", 64'(phase_word), 64'h15);
      check("R2 power-down bit", 64'(pwr_down), 64'd1);
      check("R2 mode field", 64'(mode_code), 64'd0);

      // R4: serial LSB first
      load_ser({5'h0a, 1'b0, 2'b00, 32'hcafe_0001});
      check("R5 no change while shifting", 64'(out_word()), 64'(m_act));
      commit("R4");
      check("R4 serial frequency", 64'(freq_word), 64'hcafe_0001);
      check("R4 serial phase", 64'(phase_word), 64'h0a);

      // R6: partial load then commit resets pointer
      par_byte(8'h08); par_byte(8'hff);
      commit("R6 partial");
      load_par({5'h03, 1'b0, 2'b00, 32'h0bad_f00d});
      commit("R6");
      check("R6 pointer restart frequency", 64'(freq_word), 64'h0bad_f00d);

      // R8: sixth write wraps to byte 0
      load_par({5'h01, 1'b0, 2'b00, 32'h1111_2222});
      par_byte({5'h1f, 1'b1, 2'b00});
      commit("R8");
      check("R8 wrapped byte 0 phase", 64'(phase_word), 64'h1f);
      check("R8 wrapped byte 0 freq kept", 64'(freq_word), 64'h1111_2222);

      // R7: reserved codes
      load_par({5'h02, 1'b0, 2'b01, 32'h5555_5555});
      commit("R7 parallel 01");
      check("R7 rejected freq", 64'(freq_word), 64'h1111_2222);
      load_par({5'h02, 1'b0, 2'b11, 32'h6666_6666});
      commit("R7 parallel 11");
      check("R7 parallel 11 accepted", 64'(mode_code), 64'd3);
      load_ser({5'h02, 1'b0, 2'b11, 32'h7777_7777});
      commit("R7 serial 11");
      check("R7 serial 11 rejected", 64'(freq_word), 64'h6666_6666);

      // R9: commit latency of three reference edges
      load_par({5'h04, 1'b0, 2'b00, 32'h0000_abcd});
      upd_strobe = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 old value after edge 2", 64'(freq_word), 64'h6666_6666);
      @(negedge clk);
      check("R9 new value after edge 3", 64'(freq_word), 64'h0000_abcd);
      repeat (1) @(negedge clk);
      upd_strobe = 1'b0; repeat (4) @(negedge clk);
      m_act = m_in; m_ptr = 0;

      // Random mix of both loading styles and mode codes
      for (int n = 0; n < 40; n++) begin
         logic [39:0] w;
         w = {$urandom(), $urandom()};
         if ($urandom_range(1, 0) == 0) w[33:32] = 2'b00;
         if ($urandom_range(1, 0) == 1) load_ser(w);
         else begin
            load_par(w);
            if ($urandom_range(3, 0) == 0) par_byte(8'($urandom()));
         end
         check("R5 random hold before commit", 64'(out_word()), 64'(m_act));
         commit("R7 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule